// File: doc/BRIEF.md
# Clock Generator Power Manager

This block decides, cycle by cycle, which parts of a multi-synthesizer clock generator run and which outputs drive their pins. Two active-low pins control it. The first pin either disables every output or, when a configuration bit selects full power-down, also stops every synthesizer and the reference oscillator. The second pin suspends a programmable set of synthesizers and outputs. When a synthesizer is suspended, its logic stops. When an output is suspended, it only goes to three-state. A three-stated output is modelled as an enable that is low, with the pad value resolved to 0, which stands for the weak pull-down.

A programmable source map tells the block which synthesizer, or the reference, feeds each output. The block uses this map for two things. First, it enforces the dependency rule: an output whose source is suspended is suspended as well, and a configuration that leaves such an output unmasked raises an error flag. Second, after a synthesizer restarts, the block holds its outputs off until a per-synthesizer lock timer expires. Outputs change state only while their sampled clock level is low, so the pins never see a clipped pulse.

Top module: `clkgen_pwr_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `out_en`, `pad_val`, `pll_en`, `osc_en`, `pll_locking` and `cfg_err` are all 0.
- R2: With `cfg_full_sd`=0, a low `oe_sd_n` turns every `out_en` bit off, while `pll_en` and `osc_en` stay 1.
- R3: With `cfg_full_sd`=1, a low `oe_sd_n` clears `pll_en` and `osc_en` on the next clock edge, and every output goes off.
- R4: While `susp_n` is low, `pll_en[p]` is 0 for each PLL whose `cfg_pll_susp[p]` is 1, and output `o` is off when `cfg_out_susp[o]` is 1. Outputs and PLLs outside the masks keep running.
- R5: Output `o` is treated as suspended whenever its source PLL is in `cfg_pll_susp`, even if `cfg_out_susp[o]` is 0. `cfg_err` is 1 one cycle after any such combination is presented. `cfg_err` does not depend on `susp_n`.
- R6: When `pll_en[p]` rises, `pll_locking[p]` is 1 for exactly LOCK cycles, where LOCK is LOCK_CPU for index CPU_PLL and LOCK_OTH for the other PLLs. An output fed by PLL p is enabled no earlier than edge LOCK+2 after that PLL was requested.
- R7: An `out_en` bit changes only at an edge where `out_clk` for that output is sampled 0. The one exception is a bit that turns off because its source is no longer running; that bit turns off at once.
- R8: `pad_val[o]` equals `out_clk[o]` while `out_en[o]` is 1, and is 0 (pulled low) otherwise.
- R9: In `cfg_out_src`, output o uses field [o*SRCW +: SRCW]. A value p below NPLL selects PLL p. Any value of NPLL or more selects the reference oscillator, which is ready as soon as `osc_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_sd_n | input | 1 | Active-low output-disable / shutdown pin |
| susp_n | input | 1 | Active-low suspend pin |
| cfg_full_sd | input | 1 | 1: a low `oe_sd_n` powers everything down |
| cfg_out_susp | input | NOUT | Outputs to suspend |
| cfg_pll_susp | input | NPLL | PLLs to suspend |
| cfg_out_src | input | NOUT*SRCW | Source of each output |
| out_clk | input | NOUT | Sampled level of each generated clock |
| out_en | output | NOUT | Output driver enable (0 = three-state) |
| pad_val | output | NOUT | Resolved pad value |
| pll_en | output | NPLL | PLL run enables |
| osc_en | output | 1 | Reference oscillator enable |
| pll_locking | output | NPLL | PLL is waiting for relock |
| cfg_err | output | 1 | Suspend masks violate the dependency rule |

## Verification
The bench keeps the default shape of six outputs and three PLLs. It shortens LOCK_CPU to 20 and LOCK_OTH to 5, so the exact edge at which each output returns after reset can be measured inside a short run, and the CPU timer is shown to differ from the other two. The source map mixes shared PLLs, a PLL that feeds two outputs and one output fed from the reference. With this map, forced suspension, error flagging and reference-only survival can all be reached. Holding `out_clk` high during a shutdown exercises both the low-phase wait and the immediate turn-off when the source stops.

// File: rtl/cgpm_pkg.sv
package cgpm_pkg;
  // A source code below the PLL count names a PLL; anything else is the reference.
  function automatic logic src_is_pll(input int unsigned code, input int unsigned npll);
    return code < npll;
  endfunction
endpackage

// File: rtl/cgpm_mask_check.sv
module cgpm_mask_check #(
  parameter int NOUT = 6,
  parameter int NPLL = 3,
  parameter int SRCW = 2
) (
  input  logic [NOUT-1:0]      out_mask,
  input  logic [NPLL-1:0]      pll_mask,
  input  logic [NOUT*SRCW-1:0] src_map,
  output logic [NOUT-1:0]      eff_mask,
  output logic                 dep_err
);
  import cgpm_pkg::*;

  logic [NOUT-1:0] forced;

  always_comb begin
    for (int o = 0; o < NOUT; o++) begin
      logic [SRCW-1:0] s;
      s = src_map[o*SRCW +: SRCW];
      forced[o] = 1'b0;
      for (int p = 0; p < NPLL; p++)
        if (src_is_pll(int'(s), NPLL) && int'(s) == p && pll_mask[p]) forced[o] = 1'b1;
    end
    eff_mask = out_mask | forced;
    dep_err  = |(forced & ~out_mask);
  end
endmodule

// File: rtl/cgpm_lock_timer.sv
module cgpm_lock_timer #(
  parameter int LOCK = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic ready,
  output logic locking
);
  localparam int CW = $clog2(LOCK + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= CW'(LOCK);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign ready   = en && (cnt == '0);
  assign locking = en && (cnt != '0);

  AST_RELOCK_START: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |-> locking); // R6
  AST_READY_NEEDS_WAIT: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(!en)) |-> 1'b0); // R6
endmodule

// File: rtl/cgpm_out_gate.sv
module cgpm_out_gate (
  input  logic clk,
  input  logic rst,
  input  logic want,
  input  logic lvl,
  input  logic src_run,
  output logic en,
  output logic pad
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else if (want && !lvl) en_q <= 1'b1;
    else if (!want && (!lvl || !src_run)) en_q <= 1'b0;
  end

  assign en  = en_q;
  assign pad = en_q & lvl;

  AST_RISE_LOW_PHASE: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> $past(!lvl)); // R7
  AST_FALL_LOW_OR_STOPPED: assert property (@(posedge clk) disable iff (rst)
    $fell(en_q) |-> $past(!lvl || !src_run)); // R7
endmodule

// File: rtl/clkgen_pwr_ctrl.sv
module clkgen_pwr_ctrl #(
  parameter int NOUT     = 6,
  parameter int NPLL     = 3,
  parameter int CPU_PLL  = 0,
  parameter int LOCK_CPU = 5000000,
  parameter int LOCK_OTH = 100000,
  parameter int SRCW     = $clog2(NPLL + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 oe_sd_n,
  input  logic                 susp_n,
  input  logic                 cfg_full_sd,
  input  logic [NOUT-1:0]      cfg_out_susp,
  input  logic [NPLL-1:0]      cfg_pll_susp,
  input  logic [NOUT*SRCW-1:0] cfg_out_src,
  input  logic [NOUT-1:0]      out_clk,
  output logic [NOUT-1:0]      out_en,
  output logic [NOUT-1:0]      pad_val,
  output logic [NPLL-1:0]      pll_en,
  output logic                 osc_en,
  output logic [NPLL-1:0]      pll_locking,
  output logic                 cfg_err
);
  import cgpm_pkg::*;

  logic            full_down;
  logic            susp_act;
  logic [NOUT-1:0] eff_mask;
  logic            dep_err;
  logic [NPLL-1:0] pll_ready;
  logic [NOUT-1:0] src_ready, src_run, want;

  assign full_down = !oe_sd_n && cfg_full_sd;
  assign susp_act  = !susp_n;

  cgpm_mask_check #(.NOUT(NOUT), .NPLL(NPLL), .SRCW(SRCW)) u_mask (
    .out_mask(cfg_out_susp), .pll_mask(cfg_pll_susp), .src_map(cfg_out_src),
    .eff_mask(eff_mask), .dep_err(dep_err));

  always_ff @(posedge clk) begin
    if (rst) begin
      pll_en  <= '0;
      osc_en  <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      osc_en  <= !full_down;
      pll_en  <= {NPLL{!full_down}} & ~({NPLL{susp_act}} & cfg_pll_susp);
      cfg_err <= dep_err;
    end
  end

  for (genvar p = 0; p < NPLL; p++) begin : g_lock
    localparam int LK = (p == CPU_PLL) ? LOCK_CPU : LOCK_OTH;
    cgpm_lock_timer #(.LOCK(LK)) u_lock (
      .clk(clk), .rst(rst), .en(pll_en[p]),
      .ready(pll_ready[p]), .locking(pll_locking[p]));
  end

  always_comb begin
    for (int o = 0; o < NOUT; o++) begin
      logic [SRCW-1:0] s;
      s = cfg_out_src[o*SRCW +: SRCW];
      src_ready[o] = osc_en;
      src_run[o]   = osc_en;
      for (int p = 0; p < NPLL; p++)
        if (src_is_pll(int'(s), NPLL) && int'(s) == p) begin
          src_ready[o] = pll_ready[p];
          src_run[o]   = pll_en[p];
        end
      want[o] = oe_sd_n && !(susp_act && eff_mask[o]) && src_ready[o];
    end
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    cgpm_out_gate u_gate (
      .clk(clk), .rst(rst), .want(want[o]), .lvl(out_clk[o]),
      .src_run(src_run[o]), .en(out_en[o]), .pad(pad_val[o]));
  end

  AST_FULL_SD_STOPS: assert property (@(posedge clk) disable iff (rst)
    (!oe_sd_n && cfg_full_sd) |=> (!osc_en && pll_en == '0)); // R3
  AST_SUSP_PLL_OFF: assert property (@(posedge clk) disable iff (rst)
    !susp_n |=> ((pll_en & $past(cfg_pll_susp)) == '0)); // R4
  AST_OE_ONLY_KEEPS_OSC: assert property (@(posedge clk) disable iff (rst)
    (!oe_sd_n && !cfg_full_sd) |=> osc_en); // R2
endmodule

// File: tb/clkgen_pwr_ctrl_test.sv
module clkgen_pwr_ctrl_test;
  localparam int NOUT = 6, NPLL = 3, SRCW = 2, LCPU = 20, LOTH = 5, SETTLE = 30;
  // sources: out0<-PLL0, out1/out2<-PLL1, out3/out5<-PLL2, out4<-reference (code 3)
  localparam logic [NOUT*SRCW-1:0] SRC = 12'b10_11_10_01_01_00;

  logic clk = 0, rst = 1, oe_sd_n = 1, susp_n = 1, cfg_full_sd = 0;
  logic [NOUT-1:0] cfg_out_susp = '0, out_clk = '0;
  logic [NPLL-1:0] cfg_pll_susp = '0;
  logic [NOUT-1:0] out_en, pad_val;
  logic [NPLL-1:0] pll_en, pll_locking;
  logic osc_en, cfg_err;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  clkgen_pwr_ctrl #(.NOUT(NOUT), .NPLL(NPLL), .CPU_PLL(0), .LOCK_CPU(LCPU),
    .LOCK_OTH(LOTH)) uut (
    .clk(clk), .rst(rst), .oe_sd_n(oe_sd_n), .susp_n(susp_n), .cfg_full_sd(cfg_full_sd),
    .cfg_out_susp(cfg_out_susp), .cfg_pll_susp(cfg_pll_susp), .cfg_out_src(SRC),
    .out_clk(out_clk), .out_en(out_en), .pad_val(pad_val), .pll_en(pll_en),
    .osc_en(osc_en), .pll_locking(pll_locking), .cfg_err(cfg_err));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  // {oe, susp, full, out_mask[6], pll_mask[3], exp_out[6], exp_pll[3], exp_osc, exp_err}
  localparam int NV = 8;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1,1'b1,1'b0,6'h00,3'b000, 6'h3F,3'b111,1'b1,1'b0}, // R4 baseline all running
    {1'b0,1'b1,1'b0,6'h00,3'b000, 6'h00,3'b111,1'b1,1'b0}, // R2 outputs only
    {1'b0,1'b1,1'b1,6'h00,3'b000, 6'h00,3'b000,1'b0,1'b0}, // R3 full power-down
    {1'b1,1'b0,1'b0,6'h01,3'b000, 6'h3E,3'b111,1'b1,1'b0}, // R4 one output
    {1'b1,1'b0,1'b0,6'h28,3'b100, 6'h17,3'b011,1'b1,1'b0}, // R4 PLL2 with its outputs
    {1'b1,1'b0,1'b0,6'h00,3'b010, 6'h39,3'b101,1'b1,1'b1}, // R5 forced outputs, error
    {1'b1,1'b1,1'b0,6'h00,3'b010, 6'h3F,3'b111,1'b1,1'b1}, // R5 error without suspend
    {1'b1,1'b0,1'b0,6'h2F,3'b111, 6'h10,3'b000,1'b1,1'b0}  // R9 reference output survives
  };

  initial begin
    edges(3);
    chk("R1 reset out_en", out_en, 0);
    chk("R1 reset pll_en/osc_en", {pll_en, osc_en}, 0);
    chk("R1 reset err/locking", {cfg_err, pll_locking}, 0);
    rst = 0;
    edges(1);
    chk("R1 first cycle out_en", out_en, 0);
    chk("R6 locking after start", pll_locking, 3'b111);
    edges(1);
    chk("R9 reference output at edge 2", out_en, 6'h10);
    edges(LOTH - 1); // edge LOTH+1
    chk("R6 PLL1/2 outputs still off", out_en, 6'h10);
    chk("R6 short timers done", pll_locking, 3'b001);
    edges(1);        // edge LOTH+2
    chk("R6 PLL1/2 outputs on", out_en, 6'h3E);
    edges(LCPU - LOTH - 1); // edge LCPU+1
    chk("R6 CPU output still off", out_en, 6'h3E);
    edges(1);
    chk("R6 CPU output on", out_en, 6'h3F);

    for (int v = 0; v < NV; v++) begin
      {oe_sd_n, susp_n, cfg_full_sd, cfg_out_susp, cfg_pll_susp} = VEC[v][22:11];
      edges(SETTLE);
      chk($sformatf("R2-R5 vec%0d out_en", v), out_en, VEC[v][10:5]);
      chk($sformatf("R3 R4 vec%0d pll_en", v), pll_en, VEC[v][4:2]);
      chk($sformatf("R3 vec%0d osc_en", v), osc_en, VEC[v][1]);
      chk($sformatf("R5 vec%0d cfg_err", v), cfg_err, VEC[v][0]);
    end

    // low-phase gating and pad resolution
    {oe_sd_n, susp_n, cfg_full_sd, cfg_out_susp, cfg_pll_susp} = {3'b110, 6'h00, 3'b000};
    edges(SETTLE);
    out_clk = 6'h02;
    oe_sd_n = 0;
    edges(3);
    chk("R7 held while clock high", out_en, 6'h02);
    chk("R8 pad follows clock", pad_val, 6'h02);
    out_clk = 6'h00;
    edges(1);
    chk("R7 off at low phase", out_en, 6'h00);
    out_clk = 6'h02;
    #1;
    chk("R8 pad pulled low", pad_val, 6'h00);

    // source stopped: immediate turn-off even with clocks high
    out_clk = 6'h00;
    oe_sd_n = 1;
    edges(SETTLE);
    chk("R2 outputs back", out_en, 6'h3F);
    out_clk = 6'h3F;
    cfg_full_sd = 1;
    oe_sd_n = 0;
    edges(1);
    chk("R3 sources stop next edge", {pll_en, osc_en}, 0);
    chk("R7 waits one edge", out_en, 6'h3F);
    edges(1);
    chk("R7 off once source stopped", out_en, 6'h00);
    chk("R8 pads low in shutdown", pad_val, 6'h00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule